// File: doc/BRIEF.md
# Interrupt Pin Trigger and End-of-Interrupt Tracker

This block sits behind the pins of an I/O interrupt controller and decides, pin by pin, when an interrupt has to be sent to a processor. Each pin is described by four fields held elsewhere in the controller: an active-low select, a level/edge select, a mask bit and a vector. The block keeps a pending bit and an in-service (remote) bit for every pin. When a pin needs service it is queued, and the queued pins are granted one per cycle starting from the lowest index. A granted pin that is unmasked produces a one-cycle delivery pulse that carries its vector, its trigger mode and its index.

The block also takes end-of-interrupt messages tagged with a vector. The lowest-index pin whose vector matches the message has its in-service bit released. If that pin is unmasked and still pending, it is queued again. Register access and destination resolution are handled outside this block.

Top module: `irq_pin_tracker`

## Requirements
- R1: The effective input of a pin is its raw level XOR its polarity bit. Polarity 1 makes the pin active-low.
- R2: In every cycle where the effective input is 0, the pin's pending bit is cleared at the next clock edge.
- R3: A 0-to-1 change of the effective input sets the pending bit. The pin is queued for service if it is edge-triggered (trigger bit 0) and its pending bit was clear, or if its remote bit is clear.
- R4: A granted unmasked pin gives one delivery pulse carrying the pin's vector, its trigger bit and its index. A granted unmasked level-triggered pin (trigger bit 1) also sets its remote bit.
- R5: A granted masked pin (mask bit 1) gives no delivery pulse and leaves its remote bit clear. A granted edge-triggered pin clears its pending bit whether or not it is masked.
- R6: While a level-triggered pin's remote bit is set, a new 0-to-1 change of its effective input does not produce a delivery.
- R7: An end-of-interrupt message clears the remote bit of the lowest-index pin whose vector equals the message vector, and of no other pin. A message whose vector matches no pin changes no state and produces no delivery.
- R8: If the pin matched by an end-of-interrupt message is unmasked and pending, it is queued and delivered again. For a level-triggered pin this sets its remote bit again.
- R9: Pins queued in the same cycle are granted one per cycle in ascending index order. A delivery pulse appears two clock edges after the edge that first samples the input change.
- R10: Synchronous reset clears all pending and remote bits and the delivery output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | NPINS | Raw pin levels |
| cfg_polarity | input | NPINS | Per-pin polarity: 1 = active-low |
| cfg_level_trig | input | NPINS | Per-pin trigger: 1 = level, 0 = edge |
| cfg_mask | input | NPINS | Per-pin mask: 1 = masked |
| cfg_vector | input | NPINS*VEC_W | Per-pin vector; pin i at bits [i*VEC_W +: VEC_W] |
| eoi_valid | input | 1 | End-of-interrupt message strobe |
| eoi_vector | input | VEC_W | Vector carried by the end-of-interrupt message |
| dlv_valid | output | 1 | One-cycle delivery pulse |
| dlv_pin | output | IDX_W | Index of the delivered pin (IDX_W = clog2 NPINS) |
| dlv_vector | output | VEC_W | Vector of the delivered pin |
| dlv_level | output | 1 | Trigger bit of the delivered pin |
| pin_pending | output | NPINS | Pending bit of each pin |
| pin_remote | output | NPINS | Remote (in-service) bit of each pin |

## Verification
Every pin of a four-pin configuration is run through every combination of polarity, trigger mode and mask. Each run applies the same pattern: a first assertion, a release, a second assertion and an end-of-interrupt. The delivery counts this pattern produces differ between edge and level pins and between masked and unmasked pins, so a wrong trigger rule, an ignored mask or a missing redelivery each show up as a wrong count. A simultaneous assertion on all pins shows the grant order and the delivery latency. Two level pins that share a vector, together with a message whose vector matches no pin, show the lowest-index match rule and the ignore rule.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irqt_pin_cell.sv
module irqt_pin_cell
  import irqt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  input  logic pol,
  input  logic trig,
  input  logic mask,
  input  logic grant,
  input  logic eoi_hit,
  output logic pending,
  output logic remote,
  output logic req
);
  trig_e trig_mode;
  logic  eff, eff_q, rise, is_level, svc_event, eoi_redo;
  logic  p_n, r_n, q_n;

  assign trig_mode = trig_e'(trig);
  assign is_level  = (trig_mode == TRIG_LEVEL);
  assign eff       = pin_raw ^ pol;
  assign rise      = eff & ~eff_q;
  assign svc_event = rise & ((~is_level & ~pending) | ~remote);
  assign eoi_redo  = eoi_hit & ~mask & pending;

  always_comb begin
    p_n = pending;
    r_n = remote;
    q_n = req;
    if (grant) begin
      q_n = 1'b0;
      if (!mask && is_level) r_n = 1'b1;
      if (!is_level) p_n = 1'b0;
    end
    if (eoi_hit) r_n = 1'b0;
    if (!eff) p_n = 1'b0;
    else if (rise) p_n = 1'b1;
    if (svc_event || eoi_redo) q_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_q   <= 1'b0;
      pending <= 1'b0;
      remote  <= 1'b0;
      req     <= 1'b0;
    end else begin
      eff_q   <= eff;
      pending <= p_n;
      remote  <= r_n;
      req     <= q_n;
    end
  end

  a_r2_inactive_clears: assert property (@(posedge clk) disable iff (rst)
    !eff |=> !pending);
  a_r4_level_sets_remote: assert property (@(posedge clk) disable iff (rst)
    (grant && !mask && is_level && !eoi_hit) |=> remote);
  a_r5_edge_drops_pending: assert property (@(posedge clk) disable iff (rst)
    (grant && !is_level && !rise) |=> !pending);
  a_r6_held_off: assert property (@(posedge clk) disable iff (rst)
    (rise && is_level && remote && !eoi_hit && !req) |=> !req);
  a_r7_eoi_releases: assert property (@(posedge clk) disable iff (rst)
    eoi_hit |=> !remote);
endmodule

// File: rtl/irqt_eoi_match.sv
module irqt_eoi_match #(
  parameter int unsigned NPINS = 24,
  parameter int unsigned VEC_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vector,
  input  logic [NPINS*VEC_W-1:0] vec_flat,
  output logic [NPINS-1:0]       hit
);
  logic [NPINS-1:0] match_lowest;

  // Scan downward so the lowest matching index is the one that remains.
  always_comb begin
    match_lowest = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (vec_flat[i*VEC_W +: VEC_W] == eoi_vector)
        match_lowest = NPINS'(1) << i;
    end
  end

  assign hit = eoi_valid ? match_lowest : '0;

  a_r7_single_hit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
  a_r7_hit_needs_msg: assert property (@(posedge clk) disable iff (rst)
    (|hit) |-> eoi_valid);
endmodule

// File: rtl/irqt_arbiter.sv
module irqt_arbiter #(
  parameter int unsigned NPINS = 24,
  parameter int unsigned VEC_W = 8,
  localparam int unsigned IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPINS-1:0]       req,
  input  logic [NPINS-1:0]       mask,
  input  logic [NPINS-1:0]       trig,
  input  logic [NPINS*VEC_W-1:0] vec_flat,
  output logic [NPINS-1:0]       grant,
  output logic                   dlv_valid,
  output logic [IDX_W-1:0]       dlv_pin,
  output logic [VEC_W-1:0]       dlv_vector,
  output logic                   dlv_level
);
  logic [IDX_W-1:0] sel;
  logic             found;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NPINS; i++) begin
      if (req[i] && !found) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end

  assign grant = found ? (NPINS'(1) << sel) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid  <= 1'b0;
      dlv_pin    <= '0;
      dlv_vector <= '0;
      dlv_level  <= 1'b0;
    end else begin
      dlv_valid  <= found & ~mask[sel];
      dlv_pin    <= sel;
      dlv_vector <= vec_flat[sel*VEC_W +: VEC_W];
      dlv_level  <= trig[sel];
    end
  end

  a_r5_masked_silent: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> $past(|(grant & ~mask)));
  a_r9_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker #(
  parameter int unsigned NPINS = 24,
  parameter int unsigned VEC_W = 8,
  localparam int unsigned IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPINS-1:0]       pin_level,
  input  logic [NPINS-1:0]       cfg_polarity,
  input  logic [NPINS-1:0]       cfg_level_trig,
  input  logic [NPINS-1:0]       cfg_mask,
  input  logic [NPINS*VEC_W-1:0] cfg_vector,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vector,
  output logic                   dlv_valid,
  output logic [IDX_W-1:0]       dlv_pin,
  output logic [VEC_W-1:0]       dlv_vector,
  output logic                   dlv_level,
  output logic [NPINS-1:0]       pin_pending,
  output logic [NPINS-1:0]       pin_remote
);
  logic [NPINS-1:0] req, grant, eoi_hit;

  irqt_eoi_match #(.NPINS(NPINS), .VEC_W(VEC_W)) u_eoi (
    .clk(clk), .rst(rst), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .vec_flat(cfg_vector), .hit(eoi_hit)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    irqt_pin_cell u_cell (
      .clk(clk), .rst(rst), .pin_raw(pin_level[g]), .pol(cfg_polarity[g]),
      .trig(cfg_level_trig[g]), .mask(cfg_mask[g]), .grant(grant[g]),
      .eoi_hit(eoi_hit[g]), .pending(pin_pending[g]), .remote(pin_remote[g]),
      .req(req[g])
    );
  end

  irqt_arbiter #(.NPINS(NPINS), .VEC_W(VEC_W)) u_arb (
    .clk(clk), .rst(rst), .req(req), .mask(cfg_mask), .trig(cfg_level_trig),
    .vec_flat(cfg_vector), .grant(grant), .dlv_valid(dlv_valid),
    .dlv_pin(dlv_pin), .dlv_vector(dlv_vector), .dlv_level(dlv_level)
  );

  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!dlv_valid && pin_pending == '0 && pin_remote == '0));
endmodule

// File: tb/irq_pin_tracker_tb.sv
module irq_pin_tracker_tb;
  localparam int NP  = 4;
  localparam int VW  = 4;
  localparam int IW  = 2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]    pin_level = '0, cfg_pol = '0, cfg_trig = '0, cfg_mask = '1;
  logic [NP*VW-1:0] cfg_vec = '0;
  logic             eoi_valid = 1'b0;
  logic [VW-1:0]    eoi_vector = '0;
  logic             dlv_valid, dlv_level;
  logic [IW-1:0]    dlv_pin;
  logic [VW-1:0]    dlv_vector;
  logic [NP-1:0]    pin_pending, pin_remote;

  int checks = 0, fails = 0, cyc = 0;
  int cnt [NP];
  int last_pin, last_vec, last_lvl, nlog;
  int log_pin [64];
  int log_cyc [64];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_pin_tracker #(.NPINS(NP), .VEC_W(VW)) u_dut (
    .clk(clk), .rst(rst), .pin_level(pin_level), .cfg_polarity(cfg_pol),
    .cfg_level_trig(cfg_trig), .cfg_mask(cfg_mask), .cfg_vector(cfg_vec),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .dlv_valid(dlv_valid),
    .dlv_pin(dlv_pin), .dlv_vector(dlv_vector), .dlv_level(dlv_level),
    .pin_pending(pin_pending), .pin_remote(pin_remote)
  );

  always @(negedge clk) begin
    if (dlv_valid) begin
      cnt[dlv_pin] = cnt[dlv_pin] + 1;
      last_pin = int'(dlv_pin);
      last_vec = int'(dlv_vector);
      last_lvl = int'(dlv_level);
      if (nlog < 64) begin
        log_pin[nlog] = int'(dlv_pin);
        log_cyc[nlog] = cyc;
      end
      nlog = nlog + 1;
    end
  end

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ticks(2);
    for (int k = 0; k < NP; k++) cnt[k] = 0;
    nlog = 0; last_pin = -1; last_vec = -1; last_lvl = -1;
    rst = 1'b0;
  endtask

  task automatic send_eoi(input int v);
    eoi_vector = VW'(v);
    eoi_valid  = 1'b1;
    ticks(1);
    eoi_valid  = 1'b0;
  endtask

  task automatic set_vectors();
    for (int k = 0; k < NP; k++) cfg_vec[k*VW +: VW] = VW'(k + 3);
  endtask

  task automatic run_trial(input int i, input bit pol, input bit lvl, input bit msk);
    int exp_mid;
    cfg_pol = '0; cfg_trig = '0; cfg_mask = '1; pin_level = '0;
    set_vectors();
    cfg_pol[i] = pol; cfg_trig[i] = lvl; cfg_mask[i] = msk;
    pin_level[i] = pol;
    do_reset();
    ticks(1);
    check(int'(pin_pending), 0, "R10 pending after reset");
    check(int'(pin_remote), 0, "R10 remote after reset");
    pin_level[i] = ~pol;
    ticks(4);
    check(cnt[i], msk ? 0 : 1, "R1/R3 first assertion delivery count");
    check(int'(pin_pending[i]), lvl ? 1 : 0, "R3/R5 pending after service");
    check(int'(pin_remote[i]), (lvl && !msk) ? 1 : 0, "R4/R5 remote after service");
    if (!msk) begin
      check(last_vec, i + 3, "R4 delivered vector");
      check(last_lvl, int'(lvl), "R4 delivered trigger bit");
      check(last_pin, i, "R4 delivered index");
    end
    pin_level[i] = pol;
    ticks(3);
    check(int'(pin_pending[i]), 0, "R2 pending after release");
    pin_level[i] = ~pol;
    ticks(4);
    exp_mid = msk ? 0 : (lvl ? 1 : 2);
    check(cnt[i], exp_mid, "R6 second assertion delivery count");
    send_eoi(i + 3);
    ticks(4);
    check(cnt[i], msk ? 0 : 2, "R8 count after end-of-interrupt");
    check(int'(pin_remote[i]), (lvl && !msk) ? 1 : 0, "R8 remote after end-of-interrupt");
    check(int'(pin_pending[i]), lvl ? 1 : 0, "R8 pending after end-of-interrupt");
    pin_level[i] = pol;
    ticks(2);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < NP; k++) cnt[k] = 0;
    nlog = 0;
    ticks(1);
    // Sweep every pin over polarity, trigger and mask.
    for (int i = 0; i < NP; i++)
      for (int c = 0; c < 8; c++)
        run_trial(i, c[0], c[1], c[2]);

    // R9: all pins asserted together, edge mode, unmasked.
    cfg_pol = '0; cfg_trig = '0; cfg_mask = '0; pin_level = '0;
    set_vectors();
    do_reset();
    ticks(1);
    begin
      int c0;
      pin_level = '1;
      c0 = cyc;
      ticks(8);
      check(nlog, NP, "R9 number of deliveries");
      for (int k = 0; k < NP; k++) begin
        check(log_pin[k], k, "R9 ascending grant order");
        check(log_cyc[k] - c0, 2 + k, "R9 delivery cycle");
      end
    end

    // R7: shared vector on pins 1 and 2, plus an unmatched message.
    cfg_trig = 4'b0110; cfg_mask = 4'b1001; pin_level = '0;
    set_vectors();
    cfg_vec[1*VW +: VW] = 4'd9;
    cfg_vec[2*VW +: VW] = 4'd9;
    do_reset();
    ticks(1);
    pin_level = 4'b0110;
    ticks(5);
    check(int'(pin_remote), 6, "R7 both level pins in service");
    send_eoi(15);
    ticks(3);
    check(int'(pin_remote), 6, "R7 unmatched message leaves remote");
    check(nlog, 2, "R7 unmatched message gives no delivery");
    check(int'(pin_pending), 6, "R7 unmatched message leaves pending");
    pin_level = '0;
    ticks(2);
    send_eoi(9);
    ticks(3);
    check(int'(pin_remote), 4, "R7 lowest matching pin released only");
    check(nlog, 2, "R8 no redelivery when not pending");
    done = 1'b1;
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end
endmodule